// File: doc/BRIEF.md
# Serial Receiver with Sticky Error Status

This block takes an asynchronous serial line and turns it into received characters. A sample tick that runs at sixteen times the bit rate paces it. A mode input selects 8-bit characters or 9-bit characters. A character has one low start bit, its data bits least significant first, and one stop bit. When a character completes, the block puts it in a receive buffer and raises a buffer-full flag. Software lowers that flag when it reads the buffer.

Three sticky status flags sit next to the buffer-full flag:

- **Framing error:** the stop bit was sampled low.
- **Break:** the start bit and every data bit were low. This flag rises at the last data bit, before the stop bit arrives.
- **Overrun:** a character completed while the buffer-full flag was still set.

Software clears these flags with a write-one-to-clear register write. The same write sets an interrupt-enable bit, which decides whether the error flags drive the receive interrupt.

Top module: `uart_rx_estat`

## Requirements
- R1: `rxd` passes through a two-flop synchronizer that resets to 1. After reset, `rx_data`, `rx_full`, all three error flags, `stat_ien` and `rx_irq` are all 0.
- R2: A tick that sees the synchronized line low begins a start bit. The line is sampled again 8 ticks later. If that sample is high, reception is dropped and no flag changes.
- R3: With `mode9`=0 a character has 8 data bits and `rx_data[8]` reads 0. With `mode9`=1 it has 9 data bits and the ninth lands in `rx_data[8]`. Bits arrive LSB first, one sample every 16 ticks. `mode9` is captured when the start bit is detected, so a change during a character does not affect it.
- R4: At the stop-bit sample the character is written to `rx_data` and `rx_full` goes to 1. A pulse on `rd_clr` returns `rx_full` to 0.
- R5: A stop bit sampled low sets `err_frame`. The receiver then ignores the line until it goes high. A character sent after that is received correctly.
- R6: If the start bit and every data bit were 0, `err_break` sets at the sample of the last data bit. This is bit 8 in 8-bit mode and bit 9 in 9-bit mode, and it happens before the stop-bit sample.
- R7: A character that completes while `rx_full` is 1 sets `err_overrun`. It replaces `rx_data`, and `rx_full` stays at 1.
- R8: The error flags hold until a write with `wr_en`=1 has a 1 in their bit: bit 0 clears framing, bit 1 clears break, bit 2 clears overrun. A 0 in a bit leaves that flag unchanged. A flag being set by hardware wins over a clear in the same cycle.
- R9: Every write loads `wr_data[3]` into `stat_ien`. `rx_irq` is `rx_full` OR (`stat_ien` AND any error flag).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Sample tick at 16x the bit rate |
| mode9 | input | 1 | 0: 8 data bits, 1: 9 data bits |
| rxd | input | 1 | Asynchronous serial input, idles high |
| rd_clr | input | 1 | Buffer-read pulse, clears `rx_full` |
| wr_en | input | 1 | Status register write strobe |
| wr_data | input | 4 | [2:0] write-one-to-clear flags, [3] interrupt enable |
| rx_data | output | 9 | Receive buffer |
| rx_full | output | 1 | Buffer holds an unread character |
| err_frame | output | 1 | Framing error flag |
| err_break | output | 1 | Break flag |
| err_overrun | output | 1 | Overrun flag |
| stat_ien | output | 1 | Status interrupt enable |
| rx_irq | output | 1 | Receive interrupt |

## Verification
The hardest case to reach from the ports is the early break indication. It exists only during the window between the last data sample and the stop-bit sample. The bench sends an all-zero character, pauses at the start of the stop bit, and checks that `err_break` is already set while `rx_full` is still low. The other hard case is a `mode9` change in the middle of a character. A forked process flips `mode9` two bit times after the start bit, and the bench checks that the 9-bit framing chosen at the start still governs the character.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP,
        ST_WAITHI
    } rx_state_e;

    // bit positions of the status write word
    localparam int unsigned WB_FRAME = 0;
    localparam int unsigned WB_BREAK = 1;
    localparam int unsigned WB_OVR   = 2;
    localparam int unsigned WB_IEN   = 3;
    localparam int unsigned WR_W     = 4;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sr_q;
    logic [STAGES-1:0] sr_d;

    always_comb begin
        sr_d[0] = din;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_comb begin
            sr_d[g] = sr_q[g-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '1;
        else        sr_q <= sr_d;
    end

    assign dout = sr_q[STAGES-1];
endmodule

// File: rtl/rx_frame.sv
module rx_frame
    import uart_rx_pkg::*;
#(
    parameter int unsigned OSR   = 16,
    parameter int unsigned DBITS = 8,
    localparam int unsigned MAXB = DBITS + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            mode9,
    input  logic            rxd_s,
    output logic            done,
    output logic            stop_ok,
    output logic            brk_hit,
    output logic [MAXB-1:0] frame_data
);
    localparam int unsigned CW = $clog2(OSR);
    localparam int unsigned IW = $clog2(MAXB + 1);
    localparam logic [CW-1:0] MIDC  = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] ENDC  = CW'(OSR - 1);
    localparam logic [IW-1:0] LAST8 = IW'(DBITS - 1);
    localparam logic [IW-1:0] LAST9 = IW'(MAXB - 1);

    typedef struct packed {
        rx_state_e       st;
        logic [CW-1:0]   cnt;
        logic [IW-1:0]   idx;
        logic [MAXB-1:0] shf;
        logic            nine;
        logic            allz;
    } frm_t;

    frm_t cur_q, nxt_d;
    logic [IW-1:0] last_idx;

    always_comb begin
        nxt_d    = cur_q;
        done     = 1'b0;
        stop_ok  = 1'b0;
        brk_hit  = 1'b0;
        last_idx = cur_q.nine ? LAST9 : LAST8;
        case (cur_q.st)
            ST_IDLE: begin
                if (tick && !rxd_s) begin
                    nxt_d.st   = ST_START;
                    nxt_d.cnt  = '0;
                    nxt_d.nine = mode9;
                end
            end
            ST_START: begin
                if (tick) begin
                    if (cur_q.cnt == MIDC) begin
                        nxt_d.cnt = '0;
                        if (rxd_s) begin
                            nxt_d.st = ST_IDLE;
                        end else begin
                            nxt_d.st   = ST_DATA;
                            nxt_d.idx  = '0;
                            nxt_d.shf  = '0;
                            nxt_d.allz = 1'b1;
                        end
                    end else begin
                        nxt_d.cnt = cur_q.cnt + 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (tick) begin
                    if (cur_q.cnt == ENDC) begin
                        nxt_d.cnt  = '0;
                        nxt_d.shf  = {rxd_s, cur_q.shf[MAXB-1:1]};
                        nxt_d.allz = cur_q.allz & ~rxd_s;
                        nxt_d.idx  = cur_q.idx + 1'b1;
                        if (cur_q.idx == last_idx) begin
                            nxt_d.st = ST_STOP;
                            brk_hit  = cur_q.allz & ~rxd_s;
                        end
                    end else begin
                        nxt_d.cnt = cur_q.cnt + 1'b1;
                    end
                end
            end
            ST_STOP: begin
                if (tick) begin
                    if (cur_q.cnt == ENDC) begin
                        done      = 1'b1;
                        stop_ok   = rxd_s;
                        nxt_d.cnt = '0;
                        nxt_d.st  = rxd_s ? ST_IDLE : ST_WAITHI;
                    end else begin
                        nxt_d.cnt = cur_q.cnt + 1'b1;
                    end
                end
            end
            ST_WAITHI: begin
                if (rxd_s) nxt_d.st = ST_IDLE;
            end
            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q      <= '0;
            cur_q.st   <= ST_IDLE;
            cur_q.allz <= 1'b1;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign frame_data = cur_q.nine ? cur_q.shf : (cur_q.shf >> (MAXB - DBITS));

    // R2
    glitch_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_START && tick && cur_q.cnt == MIDC && rxd_s) |=> (cur_q.st == ST_IDLE));

    // R3
    idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.idx <= IW'(MAXB)));

    // R5
    wait_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_WAITHI && !rxd_s) |=> (cur_q.st == ST_WAITHI));
endmodule

// File: rtl/rx_status.sv
module rx_status
    import uart_rx_pkg::*;
#(
    parameter int unsigned DW = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            done,
    input  logic            stop_ok,
    input  logic            brk_hit,
    input  logic [DW-1:0]   frame_data,
    input  logic            rd_clr,
    input  logic            wr_en,
    input  logic [WR_W-1:0] wr_data,
    output logic [DW-1:0]   rx_data,
    output logic            rx_full,
    output logic            err_frame,
    output logic            err_break,
    output logic            err_overrun,
    output logic            stat_ien,
    output logic            rx_irq
);
    typedef struct packed {
        logic [DW-1:0] dat;
        logic          full;
        logic          fe;
        logic          brk;
        logic          ovr;
        logic          ien;
    } sts_t;

    sts_t s_q, s_d;
    logic clr_fe, clr_brk, clr_ovr;

    always_comb begin
        s_d     = s_q;
        clr_fe  = wr_en & wr_data[WB_FRAME];
        clr_brk = wr_en & wr_data[WB_BREAK];
        clr_ovr = wr_en & wr_data[WB_OVR];
        if (clr_fe)  s_d.fe  = 1'b0;
        if (clr_brk) s_d.brk = 1'b0;
        if (clr_ovr) s_d.ovr = 1'b0;
        if (wr_en)   s_d.ien = wr_data[WB_IEN];
        if (rd_clr)  s_d.full = 1'b0;
        if (brk_hit) s_d.brk = 1'b1;
        if (done) begin
            s_d.dat  = frame_data;
            s_d.full = 1'b1;
            if (!stop_ok) s_d.fe  = 1'b1;
            if (s_q.full) s_d.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rx_data     = s_q.dat;
    assign rx_full     = s_q.full;
    assign err_frame   = s_q.fe;
    assign err_break   = s_q.brk;
    assign err_overrun = s_q.ovr;
    assign stat_ien    = s_q.ien;
    assign rx_irq      = s_q.full | (s_q.ien & (s_q.fe | s_q.brk | s_q.ovr));

    // R4
    full_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (rx_full && rx_data == $past(frame_data)));

    // R7
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rx_full) |=> err_overrun);

    // R8
    fe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_frame && !(wr_en && wr_data[WB_FRAME])) |=> err_frame);

    // R9
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_full && !stat_ien) |-> !rx_irq);
endmodule

// File: rtl/uart_rx_estat.sv
module uart_rx_estat
    import uart_rx_pkg::*;
#(
    parameter int unsigned OSR       = 16,
    parameter int unsigned DBITS     = 8,
    parameter int unsigned SYNC_STGS = 2,
    localparam int unsigned DW = DBITS + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick16,
    input  logic            mode9,
    input  logic            rxd,
    input  logic            rd_clr,
    input  logic            wr_en,
    input  logic [3:0]      wr_data,
    output logic [DW-1:0]   rx_data,
    output logic            rx_full,
    output logic            err_frame,
    output logic            err_break,
    output logic            err_overrun,
    output logic            stat_ien,
    output logic            rx_irq
);
    logic          rxd_s;
    logic          f_done;
    logic          f_stop_ok;
    logic          f_brk;
    logic [DW-1:0] f_data;

    rx_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (rxd_s)
    );

    rx_frame #(.OSR(OSR), .DBITS(DBITS)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick16),
        .mode9     (mode9),
        .rxd_s     (rxd_s),
        .done      (f_done),
        .stop_ok   (f_stop_ok),
        .brk_hit   (f_brk),
        .frame_data(f_data)
    );

    rx_status #(.DW(DW)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .done       (f_done),
        .stop_ok    (f_stop_ok),
        .brk_hit    (f_brk),
        .frame_data (f_data),
        .rd_clr     (rd_clr),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rx_data    (rx_data),
        .rx_full    (rx_full),
        .err_frame  (err_frame),
        .err_break  (err_break),
        .err_overrun(err_overrun),
        .stat_ien   (stat_ien),
        .rx_irq     (rx_irq)
    );
endmodule

// File: tb/uart_rx_estat_tb.sv
module uart_rx_estat_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16;
    logic       mode9 = 1'b0;
    logic       rxd = 1'b1;
    logic       rd_clr = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_data = '0;
    logic [8:0] rx_data;
    logic       rx_full, err_frame, err_break, err_overrun, stat_ien, rx_irq;

    int checks = 0;
    int errors = 0;
    int tdiv = 1;
    int tcnt = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) tcnt <= 0;
        else        tcnt <= (tcnt >= tdiv - 1) ? 0 : tcnt + 1;
    end
    assign tick16 = rst_n && (tcnt == 0);

    uart_rx_estat u_dut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .mode9(mode9), .rxd(rxd),
        .rd_clr(rd_clr), .wr_en(wr_en), .wr_data(wr_data), .rx_data(rx_data),
        .rx_full(rx_full), .err_frame(err_frame), .err_break(err_break),
        .err_overrun(err_overrun), .stat_ien(stat_ien), .rx_irq(rx_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bit_time();
        repeat (16 * tdiv) @(negedge clk);
    endtask

    // sends one character; optionally checks the early break window at stop start
    task automatic send_frame(input logic [8:0] v, input int nb, input logic stopv, input bit chk_brk);
        @(negedge clk);
        rxd = 1'b0;
        bit_time();
        for (int i = 0; i < nb; i++) begin
            rxd = v[i];
            bit_time();
        end
        rxd = stopv;
        if (chk_brk) begin
            repeat (2) @(negedge clk);
            check("R6 break before stop", {31'b0, err_break}, 32'd1);
            check("R6 not complete yet", {31'b0, rx_full}, 32'd0);
            repeat (16 * tdiv - 2) @(negedge clk);
        end else begin
            bit_time();
        end
        rxd = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic wr_stat(input logic [3:0] w);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    task automatic clear_all();
        @(negedge clk);
        rd_clr = 1'b1;
        wr_en = 1'b1;
        wr_data = 4'b0111;
        @(negedge clk);
        rd_clr = 1'b0;
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    task automatic frame_chk(input string req, input logic [8:0] v, input int nb);
        logic [8:0] exp_d;
        exp_d = (nb == 8) ? {1'b0, v[7:0]} : v;
        send_frame(v, nb, 1'b1, 1'b0);
        check(req, {23'b0, rx_data}, {23'b0, exp_d});
        check("R4 full set", {31'b0, rx_full}, 32'd1);
        check("R5 no frame err", {31'b0, err_frame}, 32'd0);
        check("R6 break iff zero", {31'b0, err_break}, {31'b0, exp_d == 9'd0});
        check("R7 no overrun", {31'b0, err_overrun}, 32'd0);
        clear_all();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 rx_data reset", {23'b0, rx_data}, 32'd0);
        check("R1 flags reset", {26'b0, rx_full, err_frame, err_break, err_overrun, stat_ien, rx_irq}, 32'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R3 8-bit sweep, all values
        mode9 = 1'b0;
        for (int v = 0; v < 256; v++) frame_chk("R3 data8", 9'(v), 8);

        // R3 9-bit sweep
        mode9 = 1'b1;
        for (int v = 0; v < 512; v += 5) frame_chk("R3 data9", 9'(v), 9);
        frame_chk("R3 data9 zero", 9'h000, 9);
        frame_chk("R3 data9 top", 9'h1FF, 9);

        // R2 R3 slower tick
        tdiv = 3;
        frame_chk("R3 slow tick 9", 9'h155, 9);
        mode9 = 1'b0;
        frame_chk("R3 slow tick 8", 9'h0C3, 8);
        tdiv = 1;

        // R3 mode captured at start
        mode9 = 1'b1;
        fork
            send_frame(9'h1A6, 9, 1'b1, 1'b0);
            begin
                repeat (16 * 2) @(negedge clk);
                mode9 = 1'b0;
            end
        join
        check("R3 mode latched", {23'b0, rx_data}, 32'h1A6);
        clear_all();

        // R4 read clears full
        send_frame(9'h03C, 8, 1'b1, 1'b0);
        check("R4 full before read", {31'b0, rx_full}, 32'd1);
        @(negedge clk); rd_clr = 1'b1; @(negedge clk); rd_clr = 1'b0;
        check("R4 full after read", {31'b0, rx_full}, 32'd0);
        check("R4 data kept", {23'b0, rx_data}, 32'h03C);

        // R2 glitch
        @(negedge clk); rxd = 1'b0;
        repeat (3) @(negedge clk); rxd = 1'b1;
        repeat (60) @(negedge clk);
        check("R2 glitch no full", {31'b0, rx_full}, 32'd0);
        check("R2 glitch no fe", {31'b0, err_frame}, 32'd0);
        frame_chk("R2 after glitch", 9'h05A, 8);

        // R6 R5 break with low stop, 8-bit
        send_frame(9'h000, 8, 1'b0, 1'b1);
        check("R5 frame err", {31'b0, err_frame}, 32'd1);
        check("R5 full on bad stop", {31'b0, rx_full}, 32'd1);
        check("R9 irq from full", {31'b0, rx_irq}, 32'd1);
        // R8 partial clear: break only
        wr_stat(4'b0010);
        check("R8 break cleared", {31'b0, err_break}, 32'd0);
        check("R8 frame held", {31'b0, err_frame}, 32'd1);
        clear_all();
        frame_chk("R5 recover", 9'h0A5, 8);

        // R6 9-bit break window
        mode9 = 1'b1;
        send_frame(9'h000, 9, 1'b0, 1'b1);
        check("R5 frame err 9", {31'b0, err_frame}, 32'd1);
        clear_all();

        // R7 overrun
        mode9 = 1'b0;
        send_frame(9'h011, 8, 1'b1, 1'b0);
        send_frame(9'h022, 8, 1'b1, 1'b0);
        check("R7 overrun set", {31'b0, err_overrun}, 32'd1);
        check("R7 data replaced", {23'b0, rx_data}, 32'h022);
        check("R7 full stays", {31'b0, rx_full}, 32'd1);
        @(negedge clk); rd_clr = 1'b1; @(negedge clk); rd_clr = 1'b0;
        check("R9 irq off without ien", {31'b0, rx_irq}, 32'd0);
        wr_stat(4'b1000);
        check("R9 ien set", {31'b0, stat_ien}, 32'd1);
        check("R8 zero write keeps ovr", {31'b0, err_overrun}, 32'd1);
        check("R9 irq from error", {31'b0, rx_irq}, 32'd1);
        wr_stat(4'b1100);
        check("R8 ovr cleared", {31'b0, err_overrun}, 32'd0);
        check("R9 irq low after clear", {31'b0, rx_irq}, 32'd0);
        wr_stat(4'b0000);
        check("R9 ien cleared", {31'b0, stat_ien}, 32'd0);

        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule